// File: doc/BRIEF.md
# Path Error Counter Bank with Snapshot Polling

This block keeps two 16-bit running error totals for a SONET/SDH path receiver. The first totals path parity (B3) errors. Each frame, the framing logic reports how many of the eight parity bits did not match. The second totals the path far-end block error indication that the remote end returns in the G1 path status byte. Each running total counts only the errors seen since the last poll. When a total reaches its ceiling it stays there and does not wrap.

Software polls the bank by writing to any of the four counter byte addresses or to the master address. The data written does not matter. A poll copies both running totals into holding registers and restarts both totals in the same clock cycle. An increment that arrives in the poll cycle is not lost: it becomes the first value of the new total. Software then reads the holding registers one byte at a time at its own pace. Reads change nothing in the block.

Top module: `path_err_poll_bank`

## Requirements
- R1: The parity-error holding register is read at address 0x38 (bits 7:0) and at address 0x39 (bits 15:8).
- R2: The far-end-error holding register is read at address 0x3A (bits 7:0) and at address 0x3B (bits 15:8).
- R3: In a cycle where a valid flag is high and its 4-bit value is from 0 to 8, that value is added to the matching running total. A value from 9 to 15, or a low valid flag, adds nothing.
- R4: A running total that would go past 0xFFFF stays at 0xFFFF.
- R5: A write to any address from 0x38 to 0x3B polls both counters at the same time.
- R6: A write to address 0x00 polls both counters.
- R7: A poll loads each holding register with the running total as it stood before the poll cycle. It reloads each running total with that cycle's valid increment, or with zero when there is none.
- R8: A write to any other address does not poll. The holding registers and the running totals keep their values.
- R9: A poll happens only on the first cycle of a write strobe. A strobe held high for several cycles gives exactly one snapshot. Two polls need at least one cycle with the strobe low between them.
- R10: Reads have no side effects. A read address outside 0x38 to 0x3B returns 0x00.
- R11: After reset, both running totals and both holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| rd_addr | input | 8 | Bus read address |
| rd_data | output | 8 | Byte selected by rd_addr (combinational) |
| bip_vld | input | 1 | Parity error count is valid this cycle |
| bip_errs | input | 4 | Mismatched parity bits in the frame (0 to 8) |
| febe_vld | input | 1 | Far-end error value is valid this cycle |
| febe_val | input | 4 | Far-end block error value from the path status byte |

## Verification
The assertions take for granted that the increment inputs are sampled only on rising clock edges, and that the write strobe and the write address are stable around each edge. They also take for granted that an increment arriving in a poll cycle belongs to the new counting interval. The stimulus changes every input on the falling edge, so each input holds one value for a whole cycle. It leaves idle cycles between polls, so each snapshot is read back before the holding registers change again. It drives out-of-range values only with their valid flags high, so the rule that such values add nothing is tested on its own.

// File: rtl/path_err_pkg.sv
package path_err_pkg;
  localparam int BUS_AW    = 8;
  localparam int BUS_DW    = 8;
  localparam int CNT_W     = 16;
  localparam int INC_W     = 4;
  localparam int MAX_INC   = 8;
  localparam int NUM_CNT   = 2;
  localparam int BYTES_PER = CNT_W / BUS_DW;
  localparam int GRP_SPAN  = NUM_CNT * BYTES_PER;
  localparam logic [BUS_AW-1:0] GRP_BASE    = 8'h38;
  localparam logic [BUS_AW-1:0] MASTER_ADDR = 8'h00;
endpackage

// File: rtl/poll_strobe_gen.sv
module poll_strobe_gen #(
  parameter int ADDR_W = 8,
  parameter int SPAN = 4,
  parameter logic [ADDR_W-1:0] BASE = 8'h38,
  parameter logic [ADDR_W-1:0] MASTER = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              poll_o
);
  localparam logic [ADDR_W:0] END_EXCL = {1'b0, BASE} + (ADDR_W+1)'(SPAN);

  logic wr_q;
  logic grp_hit;
  logic mst_hit;

  always_comb begin
    grp_hit = (wr_addr >= BASE) && ({1'b0, wr_addr} < END_EXCL);
    mst_hit = (wr_addr == MASTER);
    poll_o  = wr_en && !wr_q && (grp_hit || mst_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_en;
  end

  // R9: a poll cycle is never immediately followed by another
  a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |=> !poll_o);
endmodule

// File: rtl/err_accum.sv
module err_accum #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4,
  parameter int MAX_INC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_vld,
  input  logic [INC_W-1:0] inc_val,
  input  logic             poll,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q, run_nxt;
  logic [CNT_W-1:0] hold_q, hold_nxt;
  logic [CNT_W-1:0] inc_eff;
  logic [CNT_W:0]   sum;
  logic             run_en, hold_en;

  always_comb begin
    inc_eff = '0;
    if (inc_vld && (int'(inc_val) <= MAX_INC)) inc_eff = CNT_W'(inc_val);
    sum      = {1'b0, run_q} + {1'b0, inc_eff};
    run_en   = poll || (inc_eff != '0);
    if (poll)          run_nxt = inc_eff;
    else if (sum[CNT_W]) run_nxt = CEIL;
    else               run_nxt = sum[CNT_W-1:0];
    hold_en  = poll;
    hold_nxt = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      if (run_en)  run_q  <= run_nxt;
      if (hold_en) hold_q <= hold_nxt;
    end
  end

  assign hold_o = hold_q;

  // R4: a saturated total stays saturated until polled
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == CEIL && !poll) |=> run_q == CEIL);
  // R3: without a poll the total never decreases
  a_r3_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !poll |=> run_q >= $past(run_q));
  // R7: snapshot takes the pre-poll total
  a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    poll |=> hold_q == $past(run_q));
  // R7: same-cycle increment is kept in the new interval
  a_r7_carry: assert property (@(posedge clk) disable iff (!rst_n)
    poll |=> run_q == $past(inc_eff));
  // R8: holding register changes only on a poll
  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !poll |=> $stable(hold_q));
endmodule

// File: rtl/hold_read_mux.sv
module hold_read_mux #(
  parameter int NCNT = 2,
  parameter int CNT_W = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h38
) (
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [NCNT-1:0][CNT_W-1:0]  hold_i,
  output logic [DATA_W-1:0]           rd_data
);
  localparam int NB = CNT_W / DATA_W;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCNT; i++) begin
      for (int b = 0; b < NB; b++) begin
        if (rd_addr == BASE + ADDR_W'(i * NB + b))
          rd_data = hold_i[i][b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/path_err_poll_bank.sv
module path_err_poll_bank
  import path_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic [BUS_DW-1:0] rd_data,
  input  logic              bip_vld,
  input  logic [INC_W-1:0]  bip_errs,
  input  logic              febe_vld,
  input  logic [INC_W-1:0]  febe_val
);
  logic                            poll;
  logic [NUM_CNT-1:0]              vld_v;
  logic [NUM_CNT-1:0][INC_W-1:0]   val_v;
  logic [NUM_CNT-1:0][CNT_W-1:0]   hold_v;

  // counter 0: path parity, counter 1: far-end block errors
  assign vld_v = {febe_vld, bip_vld};
  assign val_v = {febe_val, bip_errs};

  poll_strobe_gen #(
    .ADDR_W(BUS_AW), .SPAN(GRP_SPAN), .BASE(GRP_BASE), .MASTER(MASTER_ADDR)
  ) u_poll (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .poll_o(poll)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    err_accum #(.CNT_W(CNT_W), .INC_W(INC_W), .MAX_INC(MAX_INC)) u_acc (
      .clk(clk), .rst_n(rst_n), .inc_vld(vld_v[g]), .inc_val(val_v[g]),
      .poll(poll), .hold_o(hold_v[g])
    );
  end

  hold_read_mux #(
    .NCNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(BUS_AW), .DATA_W(BUS_DW), .BASE(GRP_BASE)
  ) u_rd (
    .rd_addr(rd_addr), .hold_i(hold_v), .rd_data(rd_data)
  );

  // R5/R6: both holding registers move together, only on a poll
  a_r5_joint: assert property (@(posedge clk) disable iff (!rst_n)
    !poll |=> $stable(hold_v));
endmodule

// File: tb/path_err_poll_bank_tb.sv
module path_err_poll_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] rd_addr = 8'hFF;
  logic [7:0] rd_data;
  logic bip_vld = 1'b0;
  logic [3:0] bip_errs = 4'd0;
  logic febe_vld = 1'b0;
  logic [3:0] febe_val = 4'd0;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int b; int f; string tag; } snap_t;
  snap_t q[$];

  int run_b = 0, run_f = 0, hold_b = 0, hold_f = 0;
  bit wr_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  path_err_poll_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .bip_vld(bip_vld),
    .bip_errs(bip_errs), .febe_vld(febe_vld), .febe_val(febe_val)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input bit v, input int x);
    return (v && x <= 8) ? x : 0;
  endfunction

  function automatic int sat(input int a);
    return (a > 65535) ? 65535 : a;
  endfunction

  // driver: one cycle of stimulus and model update
  task automatic step(input bit bv, input int bi, input bit fv, input int fi,
                      input bit we, input logic [7:0] wa, input string tag);
    bit hit, pl;
    int eb, ef;
    @(negedge clk);
    bip_vld = bv; bip_errs = 4'(bi); febe_vld = fv; febe_val = 4'(fi);
    wr_en = we; wr_addr = wa;
    hit = (wa >= 8'h38 && wa <= 8'h3B) || wa == 8'h00;
    pl = we && !wr_prev && hit;
    wr_prev = we;
    eb = eff(bv, bi); ef = eff(fv, fi);
    if (pl) begin
      q.push_back('{run_b, run_f, tag});
      hold_b = run_b; hold_f = run_f;
      run_b = eb; run_f = ef;
    end else begin
      run_b = sat(run_b + eb); run_f = sat(run_f + ef);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00, "");
  endtask

  task automatic poll(input logic [7:0] wa, input int bi, input int fi, input string tag);
    step(1, bi, 1, fi, 1, wa, tag);
    idle(3);
  endtask

  // monitor: pops expected snapshots and reads them back after the poll edge
  initial begin
    snap_t e;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        e = q.pop_front();
        @(posedge clk); #1;
        rd_addr = 8'h38; #1; chk(rd_data, e.b & 255, {e.tag, " R1 lo"});
        rd_addr = 8'h39; #1; chk(rd_data, e.b >> 8, {e.tag, " R1 hi"});
        rd_addr = 8'h3A; #1; chk(rd_data, e.f & 255, {e.tag, " R2 lo"});
        rd_addr = 8'h3B; #1; chk(rd_data, e.f >> 8, {e.tag, " R2 hi"});
      end
    end
  end

  // direct read of the model holding values (used only while the monitor is idle)
  task automatic check_hold(input string tag);
    @(negedge clk); #1;
    rd_addr = 8'h38; #1; chk(rd_data, hold_b & 255, tag);
    rd_addr = 8'h39; #1; chk(rd_data, hold_b >> 8, tag);
    rd_addr = 8'h3A; #1; chk(rd_data, hold_f & 255, tag);
    rd_addr = 8'h3B; #1; chk(rd_data, hold_f >> 8, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > LIMIT && !done) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_hold("R11 reset");
    // R11: first poll with no events returns zero
    poll(8'h38, 0, 0, "R11 R5");
    // R3 basic accumulation, poll via high byte of far-end counter
    for (int i = 0; i < 5; i++) step(1, 3, 1, 2, 0, 8'h00, "");
    step(1, 8, 1, 8, 0, 8'h00, "");
    poll(8'h3B, 1, 4, "R3 R5 R7");
    // R3: invalid flags and out-of-range values add nothing
    for (int i = 9; i < 16; i++) step(1, i, 1, i, 0, 8'h00, "");
    for (int i = 0; i < 4; i++) step(0, 7, 0, 6, 0, 8'h00, "");
    step(1, 2, 0, 0, 0, 8'h00, "");
    poll(8'h39, 0, 0, "R3 R7");
    // R7: same-cycle increments land in the next interval
    poll(8'h3A, 5, 7, "R7 carry");
    poll(8'h00, 0, 0, "R6 R7 master");
    // R8: writes to neighbouring addresses do not poll
    for (int i = 0; i < 3; i++) step(1, 4, 1, 1, 0, 8'h00, "");
    step(1, 1, 1, 1, 1, 8'h37, ""); idle(1);
    step(1, 1, 1, 1, 1, 8'h3C, ""); idle(1);
    step(1, 1, 1, 1, 1, 8'h01, ""); idle(2);
    check_hold("R8 hold kept");
    poll(8'h00, 0, 0, "R8 R6 running kept");
    // R9: strobe held high for several cycles gives one snapshot
    for (int i = 0; i < 3; i++) step(1, 2, 1, 3, 0, 8'h00, "");
    step(1, 1, 1, 1, 1, 8'h38, "R9 first");
    step(1, 6, 1, 5, 1, 8'h38, "R9");
    step(1, 6, 1, 5, 1, 8'h3A, "R9");
    idle(3);
    poll(8'h3B, 0, 0, "R9 after held");
    // R10: repeated reads return the same bytes, other addresses read zero
    check_hold("R10 read1");
    check_hold("R10 read2");
    @(negedge clk); #1;
    rd_addr = 8'h3C; #1; chk(rd_data, 0, "R10 unmapped 0x3C");
    rd_addr = 8'h00; #1; chk(rd_data, 0, "R10 unmapped 0x00");
    rd_addr = 8'h37; #1; chk(rd_data, 0, "R10 unmapped 0x37");
    // R4: saturation at the ceiling
    for (int i = 0; i < 8300; i++) step(1, 8, 1, 1, 0, 8'h00, "");
    poll(8'h39, 3, 2, "R4 saturate");
    poll(8'h38, 0, 0, "R4 restart");
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule